// File: doc/BRIEF.md
# Interrupt latch and enable controller

This block collects interrupt requests from up to sixteen sources and decides which one the processor should take next. Each peripheral sends a one-cycle pulse, and that pulse sets a bit in a pending-request latch. The bit stays set until the source is accepted, or until software or reset clears it. A per-source enable register and a global master enable decide which pending bits may win. Source 0 is non-maskable: it ignores the master enable and has no enable bit of its own. Sources 1 to 3 are maskable but have no enable bit, so only the master enable gates them.

When a pending source is allowed, the block raises an accept request together with the 4-bit number of the winning source. It holds both values until the acceptance sequencer acknowledges them with a strobe and the same index. The acknowledge has these effects:
- It clears that latch bit.
- For a maskable source, it clears the master enable.
- For the non-maskable source, it blocks all further acceptance until a return pulse arrives.

Software reaches both registers through a byte-wide bus with four byte addresses. A write to the latch can only clear bits, so no read-modify-write is needed and a request that arrives at the same moment is never lost.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After synchronous reset, the latch is all zeros, all enable bits are zero, the master enable is zero and `acc_req` is low.
- R2: A pulse on `irq_pulse[i]` sets latch bit i on the next clock edge. The bit stays set until it is cleared.
- R3: Bus addresses are: 0 = latch bits 7:0, 1 = latch bits 15:8, 2 = enable low byte, 3 = enable high byte. In a latch write, a data bit of 0 clears the matching latch bit and a data bit of 1 leaves it unchanged.
- R4: If a request pulse and a clear (a latch write of 0 or an acknowledge) hit the same bit in the same cycle, the bit ends up set.
- R5: Enable low byte layout:
  - bit 0 is the master enable;
  - bits 7:4 enable sources 7:4;
  - bits 3:1 read as 0 and cannot be written.

  Bits 7:0 of the high byte enable sources 15:8.
- R6: When `bus_rd` is high, `bus_rdata` shows the addressed byte on the following cycle. Bits 1:0 of latch address 0 read as don't-care, and the block returns 0 there.
- R7: A pending maskable source i (1 to 15) may be accepted only when all of the following hold:
  - the master enable is 1;
  - i is below 4, or enable bit i is 1;
  - no non-maskable service is in progress.
- R8: A pending source 0 is accepted whatever the master enable and enable bits are. It is not accepted while a non-maskable service is in progress.
- R9: Among the eligible sources, the lowest index wins. `acc_idx` carries that index as a binary number.
- R10: Once `acc_req` is high, it and `acc_idx` stay unchanged until `ack_stb` arrives. `acc_req` is low in the cycle after the acknowledge.
- R11: The effects of `ack_stb` depend on `ack_idx`:
  - the latch bit `ack_idx` is cleared in every case;
  - a nonzero index clears the master enable;
  - index 0 starts a non-maskable service, which blocks all acceptance until an `nmi_ret` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pulse | input | 16 | One-cycle request pulses, one per source |
| bus_addr | input | 2 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ack_stb | input | 1 | Acceptance acknowledge from the sequencer |
| ack_idx | input | 4 | Index of the source being accepted |
| nmi_ret | input | 1 | Return from non-maskable service |
| acc_req | output | 1 | Accept request, registered |
| acc_idx | output | 4 | Index of the winning source, registered |

## Verification
The bench sweeps every maskable source against all four combinations of master enable and enable bit. A design that ignored the missing enable bits of sources 1 to 3, or that let the master enable gate the wrong way, would raise or withhold `acc_req` in the wrong cells of that sweep.

Several cases target lost or stolen requests:
- A latch write of 0 in the same cycle as a request for that bit catches a design that lets the clear win and drops the request.
- A lower-priority request arriving while an accept is already pending catches an `acc_idx` that switches before the acknowledge.
- A non-maskable service with requests pending and the master enable set catches a block that accepts anything before `nmi_ret`.

A full priority walk over sources 1 to 15 catches an inverted or off-by-one priority encoder.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {
    SEL_LAT_LO = 2'd0,
    SEL_LAT_HI = 2'd1,
    SEL_ENA_LO = 2'd2,
    SEL_ENA_HI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_latch_bank.sv
// Pending-request latch: requests set, writes of 0 and acknowledges clear,
// a request always wins over a clear in the same cycle.
module irq_latch_bank #(
  parameter int NSRC  = 16,
  parameter int DW    = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  req,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [DW-1:0]    wdata,
  input  logic             ack_stb,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [NSRC-1:0]  latch_q
);
  logic [NSRC-1:0] keep;

  always_comb begin
    keep = '1;
    if (wr_lo) keep[DW-1:0] = wdata;
    if (wr_hi) keep[NSRC-1:DW] = wdata;
    if (ack_stb) keep[ack_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= req | (latch_q & keep);
  end
endmodule

// File: rtl/irq_enable_reg.sv
// Per-source enable bits (only for sources FIRST_EN and up) plus master enable.
module irq_enable_reg #(
  parameter int NSRC     = 16,
  parameter int DW       = 8,
  parameter int FIRST_EN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  input  logic            clr_imf,
  output logic [NSRC-1:0] en_q,
  output logic            imf_q
);
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_bit
    if (gi < FIRST_EN) begin : g_none
      assign en_q[gi] = 1'b0;
    end else if (gi < DW) begin : g_lo
      always_ff @(posedge clk) begin
        if (rst)        en_q[gi] <= 1'b0;
        else if (wr_lo) en_q[gi] <= wdata[gi];
      end
    end else begin : g_hi
      always_ff @(posedge clk) begin
        if (rst)        en_q[gi] <= 1'b0;
        else if (wr_hi) en_q[gi] <= wdata[gi-DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          imf_q <= 1'b0;
    else if (clr_imf) imf_q <= 1'b0;
    else if (wr_lo)   imf_q <= wdata[0];
  end
endmodule

// File: rtl/irq_prio_pick.sv
// Lowest-index-first priority encoder.
module irq_prio_pick #(
  parameter int NSRC  = 16,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  elig,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
    any = |elig;
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int NSRC     = 16,
  parameter int FIRST_EN = 4,
  localparam int DW      = irq_pkg::BYTE_W,
  localparam int IDX_W   = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_pulse,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             ack_stb,
  input  logic [IDX_W-1:0] ack_idx,
  input  logic             nmi_ret,
  output logic             acc_req,
  output logic [IDX_W-1:0] acc_idx
);
  import irq_pkg::*;

  logic [NSRC-1:0]  latch_q, en_q, elig;
  logic             imf_q, nmi_busy_q, pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             wr_lat_lo, wr_lat_hi, wr_ena_lo, wr_ena_hi;

  assign wr_lat_lo = bus_wr && (reg_sel_e'(bus_addr) == SEL_LAT_LO);
  assign wr_lat_hi = bus_wr && (reg_sel_e'(bus_addr) == SEL_LAT_HI);
  assign wr_ena_lo = bus_wr && (reg_sel_e'(bus_addr) == SEL_ENA_LO);
  assign wr_ena_hi = bus_wr && (reg_sel_e'(bus_addr) == SEL_ENA_HI);

  irq_latch_bank #(.NSRC(NSRC), .DW(DW)) u_latch (
    .clk(clk), .rst(rst), .req(irq_pulse),
    .wr_lo(wr_lat_lo), .wr_hi(wr_lat_hi), .wdata(bus_wdata),
    .ack_stb(ack_stb), .ack_idx(ack_idx), .latch_q(latch_q)
  );

  irq_enable_reg #(.NSRC(NSRC), .DW(DW), .FIRST_EN(FIRST_EN)) u_enable (
    .clk(clk), .rst(rst), .wr_lo(wr_ena_lo), .wr_hi(wr_ena_hi),
    .wdata(bus_wdata), .clr_imf(ack_stb && (ack_idx != '0)),
    .en_q(en_q), .imf_q(imf_q)
  );

  // Eligibility: source 0 is non-maskable, the rest need the master enable.
  for (genvar gs = 0; gs < NSRC; gs++) begin : g_elig
    if (gs == 0) begin : g_nmi
      assign elig[gs] = latch_q[gs] && !nmi_busy_q;
    end else if (gs < FIRST_EN) begin : g_noen
      assign elig[gs] = latch_q[gs] && imf_q && !nmi_busy_q;
    end else begin : g_en
      assign elig[gs] = latch_q[gs] && imf_q && en_q[gs] && !nmi_busy_q;
    end
  end

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .elig(elig), .any(pick_any), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_req <= 1'b0;
      acc_idx <= '0;
    end else if (acc_req) begin
      if (ack_stb) acc_req <= 1'b0;
    end else if (pick_any) begin
      acc_req <= 1'b1;
      acc_idx <= pick_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               nmi_busy_q <= 1'b0;
    else if (ack_stb && ack_idx == '0)     nmi_busy_q <= 1'b1;
    else if (nmi_ret)                      nmi_busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (reg_sel_e'(bus_addr))
        SEL_LAT_LO: bus_rdata <= {latch_q[DW-1:2], 2'b00};
        SEL_LAT_HI: bus_rdata <= latch_q[NSRC-1:DW];
        SEL_ENA_LO: bus_rdata <= {en_q[DW-1:1], imf_q};
        SEL_ENA_HI: bus_rdata <= en_q[NSRC-1:DW];
      endcase
    end
  end
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int NSRC  = 16,
  localparam int IDX_W = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst,
  input logic [NSRC-1:0]  irq_pulse,
  input logic             ack_stb,
  input logic [IDX_W-1:0] ack_idx,
  input logic             acc_req,
  input logic [IDX_W-1:0] acc_idx,
  input logic [NSRC-1:0]  latch_q,
  input logic             imf_q,
  input logic             nmi_busy_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (latch_q == '0) && !imf_q && !acc_req);

  assert_pulse_latched_R2: assert property (@(posedge clk) disable iff (rst)
    (|irq_pulse) |=> ((latch_q & $past(irq_pulse)) == $past(irq_pulse)));

  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(acc_req) && acc_idx != '0) |-> $past(imf_q));

  assert_nmi_block_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_req) |-> !$past(nmi_busy_q));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !ack_stb) |=> acc_req && $stable(acc_idx));

  assert_ack_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_req && ack_stb) |=> !acc_req);

  assert_ack_imf_R11: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && ack_idx != '0) |=> !imf_q);

  assert_ack_nmi_R11: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && ack_idx == '0) |=> nmi_busy_q);
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .irq_pulse(irq_pulse), .ack_stb(ack_stb),
  .ack_idx(ack_idx), .acc_req(acc_req), .acc_idx(acc_idx),
  .latch_q(latch_q), .imf_q(imf_q), .nmi_busy_q(nmi_busy_q)
);

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_pulse = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ack_stb = 1'b0;
  logic [3:0]  ack_idx = '0;
  logic        nmi_ret = 1'b0;
  logic        acc_req;
  logic [3:0]  acc_idx;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  irq_latch_ctrl i_irq_latch_ctrl (
    .clk(clk), .rst(rst), .irq_pulse(irq_pulse), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack_stb(ack_stb), .ack_idx(ack_idx),
    .nmi_ret(nmi_ret), .acc_req(acc_req), .acc_idx(acc_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pulse(input logic [15:0] m);
    irq_pulse = m;
    @(negedge clk);
    irq_pulse = '0;
  endtask

  task automatic ack(input logic [3:0] k);
    ack_stb = 1'b1; ack_idx = k;
    @(negedge clk);
    ack_stb = 1'b0;
  endtask

  task automatic ret_nmi();
    nmi_ret = 1'b1;
    @(negedge clk);
    nmi_ret = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    chk(acc_req == 1'b0, "R1 acc_req", acc_req, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      if (a == 0) v = v & 8'hFC;
      chk(v == 8'h00, "R1 register reset", v, 0);
    end

    // R2/R3/R6: set each readable latch bit, write-1 keeps, write-0 clears
    for (int i = 2; i < 16; i++) begin
      logic [1:0] a;
      int b;
      a = (i < 8) ? 2'd0 : 2'd1;
      b = i % 8;
      pulse(16'(1) << i);
      idle(2);
      rd(a, v);
      chk(v[b] == 1'b1, "R2 latch set", v, 1 << b);
      wr(a, 8'hFF);
      rd(a, v);
      chk(v[b] == 1'b1, "R3 write one keeps", v, 1 << b);
      wr(a, ~(8'(1) << b));
      rd(a, v);
      chk(v == 8'h00, "R3 write zero clears", v, 0);
    end

    // R4: request and clearing write in the same cycle
    for (int s = 0; s < 2; s++) begin
      int src;
      logic [1:0] a;
      src = (s == 0) ? 5 : 12;
      a = (src < 8) ? 2'd0 : 2'd1;
      bus_addr = a; bus_wdata = 8'h00; bus_wr = 1'b1;
      irq_pulse = 16'(1) << src;
      @(negedge clk);
      bus_wr = 1'b0; irq_pulse = '0;
      rd(a, v);
      chk(v[src % 8] == 1'b1, "R4 request wins", v, 1 << (src % 8));
      wr(a, 8'h00);
    end

    // R5: enable register layout
    wr(2'd2, 8'hFF);
    rd(2'd2, v);
    chk(v == 8'hF1, "R5 enable low", v, 8'hF1);
    wr(2'd3, 8'hAB);
    rd(2'd3, v);
    chk(v == 8'hAB, "R5 enable high", v, 8'hAB);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);

    // R7/R11: every maskable source against master enable and enable bit
    for (int i = 1; i < 16; i++) begin
      for (int m = 0; m < 4; m++) begin
        bit imf, en, expect_acc;
        logic [15:0] ena;
        logic [1:0] a;
        imf = m[0];
        en = m[1];
        ena = (en && i >= 4) ? (16'(1) << i) : 16'h0;
        a = (i < 8) ? 2'd0 : 2'd1;
        wr(2'd2, ena[7:0] | {7'd0, imf});
        wr(2'd3, ena[15:8]);
        pulse(16'(1) << i);
        idle(3);
        expect_acc = imf && (i < 4 || en);
        chk(acc_req == expect_acc, "R7 gate", acc_req, expect_acc);
        if (expect_acc) begin
          chk(acc_idx == 4'(i), "R9 index", acc_idx, i);
          ack(4'(i));
          chk(acc_req == 1'b0, "R10 drop after ack", acc_req, 0);
          rd(2'd2, v);
          chk(v[0] == 1'b0, "R11 imf cleared", v, 0);
          if (i >= 2) begin
            rd(a, v);
            chk(v[i % 8] == 1'b0, "R11 latch cleared", v, 0);
          end
        end else begin
          wr(a, ~(8'(1) << (i % 8)));
        end
      end
    end
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);

    // R10: held index, then master enable re-gating
    wr(2'd3, 8'h02);
    wr(2'd2, 8'h01);
    pulse(16'(1) << 9);
    idle(2);
    chk(acc_req && acc_idx == 4'd9, "R10 first accept", acc_idx, 9);
    pulse(16'(1) << 2);
    idle(4);
    chk(acc_req && acc_idx == 4'd9, "R10 index held", acc_idx, 9);
    ack(4'd9);
    chk(acc_req == 1'b0, "R10 dropped", acc_req, 0);
    idle(3);
    chk(acc_req == 1'b0, "R7 blocked by cleared imf", acc_req, 0);
    wr(2'd2, 8'h01);
    idle(2);
    chk(acc_req && acc_idx == 4'd2, "R7 accept after imf", acc_idx, 2);
    ack(4'd2);

    // R8: non-maskable source and its service block
    pulse(16'h0001);
    idle(2);
    chk(acc_req && acc_idx == 4'd0, "R8 nmi accepted with imf=0", acc_idx, 0);
    ack(4'd0);
    wr(2'd2, 8'h21);
    pulse(16'h0021);
    idle(4);
    chk(acc_req == 1'b0, "R8 blocked in service", acc_req, 0);
    ret_nmi();
    idle(2);
    chk(acc_req && acc_idx == 4'd0, "R9 nmi wins", acc_idx, 0);
    ack(4'd0);
    idle(3);
    chk(acc_req == 1'b0, "R11 nmi blocks maskable", acc_req, 0);
    ret_nmi();
    idle(2);
    chk(acc_req && acc_idx == 4'd5, "R11 release", acc_idx, 5);
    ack(4'd5);

    // R9: full priority walk
    wr(2'd3, 8'hFF);
    wr(2'd2, 8'hF1);
    pulse(16'hFFFE);
    for (int k = 1; k < 16; k++) begin
      idle(2);
      chk(acc_req && acc_idx == 4'(k), "R9 priority order", acc_idx, k);
      ack(4'(k));
      wr(2'd2, 8'hF1);
    end
    idle(3);
    chk(acc_req == 1'b0, "R9 all served", acc_req, 0);

    finish_run();
  end
endmodule